// File: doc/BRIEF.md
# Row-Hit-First Memory Request Scheduler

This block sits between the request side of a DRAM controller and its command sequencer. It keeps a few pending requests, each carrying a source tag, a direction, a bank, a row, a column and a burst length. Every cycle it offers one of them to the sequencer. A request that targets the row already open in its bank is preferred over one that would need a precharge and an activate. This lets the requests leave in a different order from the one they arrived in, so that row switches on the memory bus are fewer.

Reordering is limited in three ways. A read whose waiting time has reached the latency bound of its source overrides any row-hit choice. The bounds are written per source after reset, and each starts at 39 cycles so that a cache-line reader stays under 40. A write cannot be offered until its data packet is complete. Two requests to the same bank, row and column always leave in arrival order. When latency QoS is switched off, the source tag has no effect and only the row-hit rule and arrival order remain.

Top module: `rowhit_sched`

## Requirements
- R1: After reset the queue is empty, `grant_valid` is 0, `push_ready` is 1, and the bound of every source is 39 cycles.
- R2: Among eligible requests with no urgent read present, one whose bank is marked open (`open_valid[bank]`=1) with `open_row[bank*4 +: 4]` equal to its row is granted before any request that misses.
- R3: Among requests of the same class (urgent, row hit, or other), the one accepted earliest is granted.
- R4: A write pushed with `push_wfull`=0 is not granted until a cycle with `wdone_valid`=1 and `wdone_src` equal to its source. After that edge it is eligible. A write pushed with `push_wfull`=1 is eligible at once.
- R5: A request is never granted while an earlier accepted request with the same bank, row and column is still queued.
- R6: With `qos_en`=1, a read whose age is at least the bound of its source is urgent and is granted ahead of every row hit. Age counts the rising edges since the edge that accepted the read, starting at 0.
- R7: A write never becomes urgent, however long it waits.
- R8: With `qos_en`=0, source tags and bounds have no effect on the choice.
- R9: The queue holds DEPTH (default 4) requests. `push_ready` is 0 while it is full. A grant with `grant_ready`=1 removes that request at the edge, and a grant not taken stays valid.
- R10: A bound written with `bound_we`=1 is used from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| qos_en | input | 1 | Enables latency-bound override for reads |
| bound_we | input | 1 | Writes a latency bound |
| bound_src | input | 2 | Source whose bound is written |
| bound_val | input | 6 | New bound in cycles |
| push_valid | input | 1 | New request offered |
| push_ready | output | 1 | Queue can accept a request |
| push_src | input | 2 | Source tag of the request |
| push_wr | input | 1 | 1 for write, 0 for read |
| push_bank | input | 2 | Bank |
| push_row | input | 4 | Row |
| push_col | input | 4 | Column |
| push_len | input | 3 | Burst length |
| push_wfull | input | 1 | Write data packet already complete |
| wdone_valid | input | 1 | Marks the pending writes of a source complete |
| wdone_src | input | 2 | Source whose write data has completed |
| open_valid | input | 4 | Per bank: a row is open |
| open_row | input | 16 | Open row of each bank, 4 bits per bank |
| grant_valid | output | 1 | A request is offered |
| grant_ready | input | 1 | Sequencer takes the offered request |
| grant_src | output | 2 | Source tag of the offered request |
| grant_wr | output | 1 | Direction of the offered request |
| grant_bank | output | 2 | Bank of the offered request |
| grant_row | output | 4 | Row of the offered request |
| grant_col | output | 4 | Column of the offered request |
| grant_len | output | 3 | Burst length of the offered request |

## Verification
The grant is combinational from registered queue state and the live open-row inputs. A request accepted at an edge is therefore visible at the next falling edge, and a change of `open_valid` or `open_row` shows in the same cycle. Write completion and bound writes take effect one edge after they are driven. A read's age equals the number of edges seen since its accepting edge, so the bound sweep checks the grant at every falling edge from age 0 to bound+1. The urgent read must take over exactly at the falling edge where the age equals the bound.

// File: rtl/rhs_pkg.sv
package rhs_pkg;
    localparam int SRC_W     = 2;
    localparam int NSRC      = 1 << SRC_W;
    localparam int BANK_W    = 2;
    localparam int NBANK     = 1 << BANK_W;
    localparam int ROW_W     = 4;
    localparam int COL_W     = 4;
    localparam int LEN_W     = 3;
    localparam int BOUND_W   = 6;
    localparam int RST_BOUND = 39;

    typedef struct packed {
        logic [SRC_W-1:0]  src;
        logic              wr;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [LEN_W-1:0]  len;
    } req_t;

    function automatic logic same_addr(req_t a, req_t b);
        return (a.bank == b.bank) && (a.row == b.row) && (a.col == b.col);
    endfunction
endpackage

// File: rtl/rhs_bounds.sv
module rhs_bounds
    import rhs_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [SRC_W-1:0]   src,
    input  logic [BOUND_W-1:0] val,
    output logic [BOUND_W-1:0] bound [NSRC]
);
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NSRC; s++) bound[s] <= BOUND_W'(RST_BOUND);
        end else if (we) begin
            bound[src] <= val;
        end
    end
endmodule

// File: rtl/rhs_store.sv
module rhs_store
    import rhs_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               push_en,
    input  req_t               push_req,
    input  logic               push_wfull,
    input  logic               wdone_valid,
    input  logic [SRC_W-1:0]   wdone_src,
    input  logic               pop_en,
    input  logic [IDX_W-1:0]   pop_idx,
    output req_t               ent   [DEPTH],
    output logic [DEPTH-1:0]   vld,
    output logic [DEPTH-1:0]   wok,
    output logic [BOUND_W-1:0] age   [DEPTH],
    output logic [DEPTH-1:0]   older [DEPTH],
    output logic [CNT_W-1:0]   count,
    output logic               full
);
    logic [IDX_W-1:0] slot;
    logic             found;

    always_comb begin
        slot  = '0;
        found = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!vld[i] && !found) begin
                slot  = IDX_W'(i);
                found = 1'b1;
            end
        end
    end

    assign count = CNT_W'($countones(vld));
    assign full  = (count == CNT_W'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= '0;
            wok <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                ent[i]   <= '0;
                age[i]   <= '0;
                older[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (vld[i] && age[i] != '1) age[i] <= age[i] + 1'b1;
                if (wdone_valid && vld[i] && ent[i].src == wdone_src) wok[i] <= 1'b1;
            end
            if (pop_en) vld[pop_idx] <= 1'b0;
            if (push_en) begin
                ent[slot] <= push_req;
                vld[slot] <= 1'b1;
                wok[slot] <= !push_req.wr || push_wfull;
                age[slot] <= '0;
                for (int j = 0; j < DEPTH; j++) begin
                    older[j][slot] <= vld[j] && !(pop_en && pop_idx == IDX_W'(j));
                    older[slot][j] <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/rhs_pick.sv
module rhs_pick
    import rhs_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  req_t                        ent   [DEPTH],
    input  logic [DEPTH-1:0]            vld,
    input  logic [DEPTH-1:0]            wok,
    input  logic [BOUND_W-1:0]          age   [DEPTH],
    input  logic [DEPTH-1:0]            older [DEPTH],
    input  logic [NBANK-1:0]            open_valid,
    input  logic [NBANK-1:0][ROW_W-1:0] open_row,
    input  logic                        qos_en,
    input  logic [BOUND_W-1:0]          bound [NSRC],
    output logic                        sel_valid,
    output logic [IDX_W-1:0]            sel_idx
);
    logic [DEPTH-1:0] elig, hit, urg, cand;
    logic             win;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            elig[i] = vld[i] && wok[i];
            for (int j = 0; j < DEPTH; j++) begin
                if (vld[j] && older[j][i] && same_addr(ent[j], ent[i])) elig[i] = 1'b0;
            end
            hit[i] = open_valid[ent[i].bank] && (open_row[ent[i].bank] == ent[i].row);
            urg[i] = qos_en && !ent[i].wr && (age[i] >= bound[ent[i].src]);
        end
        cand = elig & urg;
        if (cand == '0) cand = elig & hit;
        if (cand == '0) cand = elig;
        sel_valid = 1'b0;
        sel_idx   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            win = cand[i];
            for (int j = 0; j < DEPTH; j++) begin
                if (cand[j] && older[j][i]) win = 1'b0;
            end
            if (win && !sel_valid) begin
                sel_valid = 1'b1;
                sel_idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/rowhit_sched.sv
module rowhit_sched
    import rhs_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     qos_en,
    input  logic                     bound_we,
    input  logic [SRC_W-1:0]         bound_src,
    input  logic [BOUND_W-1:0]       bound_val,
    input  logic                     push_valid,
    output logic                     push_ready,
    input  logic [SRC_W-1:0]         push_src,
    input  logic                     push_wr,
    input  logic [BANK_W-1:0]        push_bank,
    input  logic [ROW_W-1:0]         push_row,
    input  logic [COL_W-1:0]         push_col,
    input  logic [LEN_W-1:0]         push_len,
    input  logic                     push_wfull,
    input  logic                     wdone_valid,
    input  logic [SRC_W-1:0]         wdone_src,
    input  logic [NBANK-1:0]         open_valid,
    input  logic [NBANK*ROW_W-1:0]   open_row,
    output logic                     grant_valid,
    input  logic                     grant_ready,
    output logic [SRC_W-1:0]         grant_src,
    output logic                     grant_wr,
    output logic [BANK_W-1:0]        grant_bank,
    output logic [ROW_W-1:0]         grant_row,
    output logic [COL_W-1:0]         grant_col,
    output logic [LEN_W-1:0]         grant_len
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    req_t               push_req;
    req_t               ent   [DEPTH];
    logic [DEPTH-1:0]   vld, wok;
    logic [BOUND_W-1:0] age   [DEPTH];
    logic [DEPTH-1:0]   older [DEPTH];
    logic [BOUND_W-1:0] bound [NSRC];
    logic [CNT_W-1:0]   cnt;
    logic               full, push_en, pop_en, sel_valid;
    logic [IDX_W-1:0]   sel_idx;
    req_t               sel;

    assign push_req   = '{src: push_src, wr: push_wr, bank: push_bank,
                          row: push_row, col: push_col, len: push_len};
    assign push_ready = !full;
    assign push_en    = push_valid && push_ready;
    assign pop_en     = sel_valid && grant_ready;

    rhs_bounds u_bounds (
        .clk(clk), .rst(rst), .we(bound_we), .src(bound_src), .val(bound_val), .bound(bound)
    );

    rhs_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst), .push_en(push_en), .push_req(push_req), .push_wfull(push_wfull),
        .wdone_valid(wdone_valid), .wdone_src(wdone_src), .pop_en(pop_en), .pop_idx(sel_idx),
        .ent(ent), .vld(vld), .wok(wok), .age(age), .older(older), .count(cnt), .full(full)
    );

    rhs_pick #(.DEPTH(DEPTH)) u_pick (
        .ent(ent), .vld(vld), .wok(wok), .age(age), .older(older),
        .open_valid(open_valid), .open_row(open_row), .qos_en(qos_en), .bound(bound),
        .sel_valid(sel_valid), .sel_idx(sel_idx)
    );

    assign sel         = ent[sel_idx];
    assign grant_valid = sel_valid;
    assign grant_src   = sel.src;
    assign grant_wr    = sel.wr;
    assign grant_bank  = sel.bank;
    assign grant_row   = sel.row;
    assign grant_col   = sel.col;
    assign grant_len   = sel.len;
endmodule

// File: rtl/rhs_checker.sv
module rhs_checker #(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] count,
    input logic             push_valid,
    input logic             push_ready,
    input logic             grant_valid,
    input logic             grant_ready,
    input logic             grant_wr,
    input logic             sel_wok
);
    assert_empty_no_grant_R1: assert property (@(posedge clk) disable iff (rst)
        count == '0 |-> !grant_valid);

    assert_full_blocks_push_R9: assert property (@(posedge clk) disable iff (rst)
        count == CNT_W'(DEPTH) |-> !push_ready);

    assert_grant_held_R9: assert property (@(posedge clk) disable iff (rst)
        grant_valid && !grant_ready |=> grant_valid);

    assert_pop_shrinks_R9: assert property (@(posedge clk) disable iff (rst)
        grant_valid && grant_ready && !(push_valid && push_ready)
        |=> int'(count) == int'($past(count)) - 1);

    assert_write_complete_R4: assert property (@(posedge clk) disable iff (rst)
        grant_valid && grant_wr |-> sel_wok);
endmodule

bind rowhit_sched rhs_checker #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .count(cnt), .push_valid(push_valid), .push_ready(push_ready),
    .grant_valid(grant_valid), .grant_ready(grant_ready), .grant_wr(grant_wr),
    .sel_wok(wok[sel_idx])
);

// File: tb/rowhit_sched_tb.sv
`timescale 1ns/1ps
module rowhit_sched_tb;
    import rhs_pkg::*;

    logic clk = 0, rst = 1, qos_en = 1, bound_we = 0;
    logic [SRC_W-1:0] bound_src = 0;
    logic [BOUND_W-1:0] bound_val = 0;
    logic push_valid = 0, push_wr = 0, push_wfull = 0, wdone_valid = 0, grant_ready = 0;
    logic push_ready, grant_valid, grant_wr;
    logic [SRC_W-1:0] push_src = 0, wdone_src = 0, grant_src;
    logic [BANK_W-1:0] push_bank = 0, grant_bank;
    logic [ROW_W-1:0] push_row = 0, grant_row;
    logic [COL_W-1:0] push_col = 0, grant_col;
    logic [LEN_W-1:0] push_len = 0, grant_len;
    logic [NBANK-1:0] open_valid = 0;
    logic [NBANK*ROW_W-1:0] open_row = 0;

    int total = 0, fails = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    rowhit_sched u_dut (.*);

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic expect_row(input int row, input string tag);
        check(grant_valid === 1'b1, tag, int'(grant_valid), 1);
        check(grant_row === ROW_W'(row), tag, int'(grant_row), row);
    endtask

    task automatic push(input int src, input bit wr, input int bank, input int row,
                        input int col, input bit wfull);
        push_valid = 1; push_src = SRC_W'(src); push_wr = wr; push_bank = BANK_W'(bank);
        push_row = ROW_W'(row); push_col = COL_W'(col); push_len = 3'd4; push_wfull = wfull;
        @(negedge clk);
        push_valid = 0;
    endtask

    task automatic set_bound(input int src, input int val);
        bound_we = 1; bound_src = SRC_W'(src); bound_val = BOUND_W'(val);
        @(negedge clk);
        bound_we = 0;
    endtask

    task automatic open_bank(input int bank, input int row);
        open_valid[bank] = 1'b1;
        open_row[bank*ROW_W +: ROW_W] = ROW_W'(row);
    endtask

    task automatic wdone(input int src);
        wdone_valid = 1; wdone_src = SRC_W'(src);
        @(negedge clk);
        wdone_valid = 0;
    endtask

    task automatic pop1();
        grant_ready = 1;
        @(negedge clk);
        grant_ready = 0;
    endtask

    task automatic drain();
        open_valid = '0;
        grant_ready = 1;
        for (int s = 0; s < NSRC; s++) wdone(s);
        repeat (6) @(negedge clk);
        grant_ready = 0;
        qos_en = 1;
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check(grant_valid === 1'b0, "R1 grant after reset", int'(grant_valid), 0);
        check(push_ready === 1'b1, "R1 ready after reset", int'(push_ready), 1);

        // R3 oldest first among misses; R9 handshake removes the head
        push(0, 0, 0, 1, 0, 0); push(1, 0, 1, 2, 0, 0); push(2, 0, 2, 3, 0, 0);
        expect_row(1, "R3 oldest miss");
        pop1();
        expect_row(2, "R9 next after pop");
        drain();

        // R2 row hit wins over older miss; two hits pick the older (R3)
        push(0, 0, 0, 1, 0, 0); push(0, 0, 1, 2, 0, 0); push(0, 0, 2, 3, 0, 0);
        open_bank(1, 2);
        #1 expect_row(2, "R2 hit over miss");
        open_bank(2, 3);
        #1 expect_row(2, "R3 oldest of two hits");
        open_valid[1] = 1'b0;
        #1 expect_row(3, "R2 remaining hit");
        @(negedge clk);
        drain();

        // R4 incomplete write waits for its packet
        push(2, 1, 0, 4, 0, 0);
        check(grant_valid === 1'b0, "R4 incomplete write held", int'(grant_valid), 0);
        wdone(1);
        check(grant_valid === 1'b0, "R4 other source completion", int'(grant_valid), 0);
        wdone(2);
        expect_row(4, "R4 write after completion");
        check(grant_wr === 1'b1, "R4 grant is write", int'(grant_wr), 1);
        drain();

        // R5 same address keeps order even against a row hit
        push(2, 1, 3, 11, 2, 0); push(0, 0, 3, 11, 2, 0); push(0, 0, 0, 12, 0, 0);
        open_bank(3, 11);
        #1 expect_row(12, "R5 only unrelated request eligible");
        @(negedge clk);
        pop1();
        check(grant_valid === 1'b0, "R5 younger same-address read blocked", int'(grant_valid), 0);
        wdone(2);
        check(grant_wr === 1'b1, "R5 older write first", int'(grant_wr), 1);
        pop1();
        check(grant_valid === 1'b1 && grant_wr === 1'b0, "R5 read after write",
              int'(grant_wr), 0);
        drain();

        // R6 R10 bound sweep: miss read of source 1 overtakes a hit at age == bound
        for (int b = 1; b <= 5; b++) begin
            set_bound(1, b);
            open_bank(1, 5);
            push(2, 0, 1, 5, 0, 0);
            push(1, 0, 2, 6, 0, 0);
            for (int n = 0; n <= b + 1; n++) begin
                expect_row((n >= b) ? 6 : 5, $sformatf("R6 R10 bound %0d age %0d", b, n));
                @(negedge clk);
            end
            drain();
        end

        // R7 writes never urgent
        set_bound(1, 1);
        open_bank(1, 8);
        push(1, 1, 2, 7, 0, 1); push(2, 0, 1, 8, 0, 0);
        repeat (10) @(negedge clk);
        expect_row(8, "R7 old write not urgent");
        drain();

        // R8 QoS off ignores bounds
        qos_en = 0;
        set_bound(1, 1);
        open_bank(1, 9);
        push(2, 0, 1, 9, 0, 0); push(1, 0, 2, 10, 0, 0);
        repeat (5) @(negedge clk);
        expect_row(9, "R8 qos off keeps hit");
        qos_en = 1;
        #1 expect_row(10, "R8 qos on again urgent");
        @(negedge clk);
        drain();

        // R1 default bound 39 for an unprogrammed source; hit is a write so never urgent
        open_bank(1, 13);
        push(2, 1, 1, 13, 0, 1); push(3, 0, 2, 14, 0, 0);
        repeat (38) @(negedge clk);
        expect_row(13, "R1 default bound age 38");
        @(negedge clk);
        expect_row(14, "R1 default bound age 39");
        drain();

        // R9 capacity
        push(0, 0, 0, 1, 0, 0); push(0, 0, 0, 2, 0, 0); push(0, 0, 0, 3, 0, 0);
        check(push_ready === 1'b1, "R9 ready below depth", int'(push_ready), 1);
        push(0, 0, 0, 4, 0, 0);
        check(push_ready === 1'b0, "R9 full", int'(push_ready), 0);
        push(0, 0, 0, 15, 0, 0);
        grant_ready = 1;
        repeat (4) @(negedge clk);
        grant_ready = 0;
        check(grant_valid === 1'b0, "R9 rejected push not stored", int'(grant_valid), 0);

        report();
    end
endmodule